// File: doc/BRIEF.md
# Manchester frame transmitter

This block sends one frame of fixed layout on a single serial line using Manchester coding. A start strobe captures a short header and a data word. The block then produces an extended start symbol followed by four fields, most significant bit first: the header, the data word, a check word that is always zero, and a parity word that the block computes itself. The receiving side can use the long start symbol to find the frame boundary, and the parity word to spot a corrupted column.

All timing comes from the system clock. One parameter sets the number of clocks in a data half-bit and another sets the number of clocks in each half of the start symbol. A host raises the start strobe for one clock while the busy flag is low. It then waits for the one-clock done pulse, or for busy to fall, before it starts the next frame. Between frames the line rests low.

Top module: `mfrm_tx`

## Requirements
- R1: While reset is asserted, and in the cycle after it is asserted asynchronously, `tx_o`, `busy_o` and `done_o` are all low.
- R2: A start request is accepted on a clock edge where `start_i` is high and no frame is in progress. From that edge `busy_o` is high, and the line is high for START_CYC clocks and then low for START_CYC clocks.
- R3: Every bit after the start symbol takes two halves of HALF_CYC clocks each. A 1 is sent as high then low, and a 0 as low then high.
- R4: After the start symbol the fields go out in a fixed order: the HDR_W-bit header, then the WORD_W-bit data word, then the check word, then the parity word. Each field is sent MSB first, and its value is the one captured on the accepting edge.
- R5: The check word is all zeros.
- R6: Bit i of the parity word makes the number of ones odd across header bit i (counted only when i < HDR_W), data bit i, check bit i and parity bit i. Bit 0 is the LSB of each field.
- R7: On the edge that ends the last half of the parity word, `done_o` goes high for exactly one clock, `busy_o` falls and the line returns low.
- R8: A start request made while a frame is in progress has no effect. The frame on the line continues unchanged, even if the header and data inputs change at that time.
- R9: With no request pending the line stays low and busy stays low. A request in the cycle where `done_o` is high is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one frame |
| hdr_i | input | HDR_W | Header value, captured on acceptance |
| data_i | input | WORD_W | Data word, captured on acceptance |
| tx_o | output | 1 | Manchester-coded serial line |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-clock pulse when a frame ends |

## Verification
If the half-period counter is wrong, some half-bit changes length, and a receiver sampling the line sees it within the first 30 clocks of a frame. If the field register is loaded or shifted wrongly, a decoded field comes out wrong in the cycle where its bits leave the line. If the parity is wrong, it shows only in the last 320 clocks of a frame. If the bit index or the sequencer state is wrong, the frame length moves, and done arrives early or late by at least one half-bit. A start request that gets through while busy restarts the start symbol in the middle of a field, which breaks the Manchester form of that bit straight away.

// File: rtl/mfrm_pkg.sv
package mfrm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SYM_HI = 2'd1,
      ST_SYM_LO = 2'd2,
      ST_BITS = 2'd3
   } mfrm_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mfrm_parity.sv
module mfrm_parity #(
   parameter int HDR_W  = 5,
   parameter int WORD_W = 32
) (
   input  logic [HDR_W-1:0]  hdr_i,
   input  logic [WORD_W-1:0] data_i,
   output logic [WORD_W-1:0] par_o
);

   initial begin
      assert (HDR_W >= 1 && HDR_W <= WORD_W)
         else $error("mfrm_parity: HDR_W must lie in 1..WORD_W");
   end

   // Check word is all zeros and so adds no ones to any column.
   for (genvar i = 0; i < WORD_W; i++) begin : g_col
      if (i < HDR_W) begin : g_with_hdr
         assign par_o[i] = ~(hdr_i[i] ^ data_i[i]);
      end else begin : g_data_only
         assign par_o[i] = ~data_i[i];
      end
   end

endmodule

// File: rtl/mfrm_halfcnt.sv
module mfrm_halfcnt #(
   parameter int MAX_CYC = 15,
   localparam int CW     = $clog2(MAX_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (MAX_CYC >= 1) else $error("mfrm_halfcnt: MAX_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAX_CYC - 1)); // R3

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/mfrm_shreg.sv
module mfrm_shreg #(
   parameter int W = 101
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         shift_i,
   output logic         head_o,
   output logic         next_o
);

   logic [W-1:0] q;

   initial begin
      assert (W >= 2) else $error("mfrm_shreg: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load_i) begin
         q <= load_val_i;
      end else if (shift_i) begin
         q <= {q[W-2:0], 1'b0};
      end
   end

   assign head_o = q[W-1];
   assign next_o = q[W-2];

   AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !shift_i) |=> $stable(q)); // R8

   AST_SR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && shift_i) |=> (head_o == $past(next_o))); // R4

endmodule

// File: rtl/mfrm_tx.sv
module mfrm_tx #(
   parameter int HDR_W     = 5,
   parameter int WORD_W    = 32,
   parameter int HALF_CYC  = 5,
   parameter int START_CYC = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [HDR_W-1:0]  hdr_i,
   input  logic [WORD_W-1:0] data_i,
   output logic              tx_o,
   output logic              busy_o,
   output logic              done_o
);
   import mfrm_pkg::*;

   localparam int NBITS = HDR_W + 3 * WORD_W;
   localparam int MAXC  = max_int(HALF_CYC, START_CYC);
   localparam int CW    = $clog2(MAXC + 1);
   localparam int IW    = $clog2(NBITS);
   localparam logic [IW-1:0] LAST_IDX  = IW'(NBITS - 1);
   localparam logic [CW-1:0] HALF_LD   = CW'(HALF_CYC - 1);
   localparam logic [CW-1:0] START_LD  = CW'(START_CYC - 1);

   initial begin
      assert (HALF_CYC >= 1)  else $error("mfrm_tx: HALF_CYC must be at least 1");
      assert (START_CYC >= 1) else $error("mfrm_tx: START_CYC must be at least 1");
      assert (HDR_W >= 1 && HDR_W <= WORD_W)
         else $error("mfrm_tx: HDR_W must lie in 1..WORD_W");
   end

   mfrm_state_e       state_q;
   logic              half_q;
   logic [IW-1:0]     idx_q;
   logic              tx_q, busy_q, done_q;

   logic [WORD_W-1:0] par_w;
   logic [NBITS-1:0]  frame_w;
   logic              accept;
   logic              last_bit;
   logic              cnt_load, cnt_zero;
   logic [CW-1:0]     cnt_val;
   logic              sh_shift, sh_head, sh_next;

   mfrm_parity #(.HDR_W(HDR_W), .WORD_W(WORD_W)) u_par (
      .hdr_i (hdr_i),
      .data_i(data_i),
      .par_o (par_w)
   );

   assign frame_w  = {hdr_i, data_i, {WORD_W{1'b0}}, par_w};
   assign accept   = (state_q == ST_IDLE) && start_i;
   assign last_bit = (idx_q == LAST_IDX);

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = HALF_LD;
      sh_shift = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               cnt_load = 1'b1;
               cnt_val  = START_LD;
            end
         end
         ST_SYM_HI: begin
            if (cnt_zero) begin
               cnt_load = 1'b1;
               cnt_val  = START_LD;
            end
         end
         ST_SYM_LO: begin
            if (cnt_zero) cnt_load = 1'b1;
         end
         ST_BITS: begin
            if (cnt_zero && !(half_q && last_bit)) cnt_load = 1'b1;
            if (cnt_zero && half_q && !last_bit)   sh_shift = 1'b1;
         end
         default: ;
      endcase
   end

   mfrm_halfcnt #(.MAX_CYC(MAXC)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (cnt_load),
      .load_val_i(cnt_val),
      .zero_o    (cnt_zero)
   );

   mfrm_shreg #(.W(NBITS)) u_sr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept),
      .load_val_i(frame_w),
      .shift_i   (sh_shift),
      .head_o    (sh_head),
      .next_o    (sh_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         half_q  <= 1'b0;
         idx_q   <= '0;
         tx_q    <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_SYM_HI;
                  tx_q    <= 1'b1;
                  busy_q  <= 1'b1;
               end
            end
            ST_SYM_HI: begin
               if (cnt_zero) begin
                  state_q <= ST_SYM_LO;
                  tx_q    <= 1'b0;
               end
            end
            ST_SYM_LO: begin
               if (cnt_zero) begin
                  state_q <= ST_BITS;
                  half_q  <= 1'b0;
                  idx_q   <= '0;
                  tx_q    <= sh_head;
               end
            end
            ST_BITS: begin
               if (cnt_zero) begin
                  if (!half_q) begin
                     half_q <= 1'b1;
                     tx_q   <= ~sh_head;
                  end else if (last_bit) begin
                     state_q <= ST_IDLE;
                     half_q  <= 1'b0;
                     tx_q    <= 1'b0;
                     busy_q  <= 1'b0;
                     done_q  <= 1'b1;
                  end else begin
                     half_q <= 1'b0;
                     idx_q  <= idx_q + 1'b1;
                     tx_q   <= sh_next;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tx_o   = tx_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> tx_o); // R2

   AST_MID_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BITS && !half_q && cnt_zero) |=> (tx_o != $past(tx_o))); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !tx_o)); // R7

   AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o) |=> busy_o || done_o); // R8

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !tx_o); // R9

endmodule

// File: tb/tb_mfrm_tx.sv
module tb_mfrm_tx;

   localparam int HW    = 5;
   localparam int WW    = 32;
   localparam int HC    = 5;
   localparam int SC    = 15;
   localparam int NB    = HW + 3 * WW;
   localparam int FLEN  = 2 * SC + 2 * HC * NB;
   localparam int NVEC  = 6;

   localparam logic [HW+WW-1:0] VEC [0:NVEC-1] = '{
      {5'h00, 32'h0000_0000},
      {5'h1F, 32'hFFFF_FFFF},
      {5'h15, 32'hA5A5_0F0F},
      {5'h0A, 32'h1234_5678},
      {5'h01, 32'h8000_0001},
      {5'h10, 32'hDEAD_BEEF}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [HW-1:0] hdr_i = '0;
   logic [WW-1:0] data_i = '0;
   logic          tx_o, busy_o, done_o;

   int checks = 0;
   int errors = 0;
   logic line_s [0:FLEN-1];

   always #10 clk = ~clk;

   mfrm_tx #(.HDR_W(HW), .WORD_W(WW), .HALF_CYC(HC), .START_CYC(SC)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .hdr_i(hdr_i),
      .data_i(data_i), .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] ref_par(input logic [HW-1:0] h, input logic [WW-1:0] d);
      logic [WW-1:0] p;
      for (int i = 0; i < WW; i++) begin
         int ones;
         ones = int'(d[i]) + ((i < HW) ? int'(h[i]) : 0);
         p[i] = (ones % 2 == 0);
      end
      return p;
   endfunction

   // Caller sets start_i and the inputs at a falling edge, then calls this.
   task automatic capture(input logic [HW-1:0] h, input logic [WW-1:0] d, input bit mid);
      logic [NB-1:0] fb;
      bit sym_ok, man_ok;
      logic busy0;
      for (int k = 0; k <= FLEN; k++) begin
         @(negedge clk);
         if (k == 0) begin
            start_i = 1'b0;
            busy0 = busy_o;
         end
         if (mid && k == 200) begin
            start_i = 1'b1;
            hdr_i = ~h;
            data_i = ~d;
         end
         if (mid && k == 201) start_i = 1'b0;
         if (k < FLEN) line_s[k] = tx_o;
      end
      chk(busy0 == 1'b1, "R2 busy after accept", 64'(busy0), 64'd1);
      chk(done_o && !busy_o && !tx_o, "R7 done/busy/line at frame end",
          {61'd0, done_o, busy_o, tx_o}, 64'h4);
      sym_ok = 1'b1;
      for (int k = 0; k < 2 * SC; k++) if (line_s[k] != (k < SC)) sym_ok = 1'b0;
      chk(sym_ok, "R2 start symbol", 64'(sym_ok), 64'd1);
      man_ok = 1'b1;
      for (int j = 0; j < NB; j++) begin
         int b;
         b = 2 * SC + 2 * HC * j;
         for (int c = 1; c < HC; c++) begin
            if (line_s[b + c] != line_s[b]) man_ok = 1'b0;
            if (line_s[b + HC + c] != line_s[b + HC]) man_ok = 1'b0;
         end
         if (line_s[b] == line_s[b + HC]) man_ok = 1'b0;
         fb[NB - 1 - j] = line_s[b];
      end
      chk(man_ok, "R3 Manchester halves", 64'(man_ok), 64'd1);
      chk(fb[NB-1 -: HW] == h, "R4 header field", 64'(fb[NB-1 -: HW]), 64'(h));
      chk(fb[3*WW-1 -: WW] == d, "R4 data field", 64'(fb[3*WW-1 -: WW]), 64'(d));
      chk(fb[2*WW-1 -: WW] == '0, "R5 check word", 64'(fb[2*WW-1 -: WW]), 64'd0);
      chk(fb[WW-1:0] == ref_par(h, d), "R6 parity word", 64'(fb[WW-1:0]),
          64'(ref_par(h, d)));
   endtask

   initial begin
      repeat (5000 * 20) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!tx_o && !busy_o && !done_o, "R1 reset outputs",
          {61'd0, tx_o, busy_o, done_o}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Table walk; each next frame is requested in the done cycle (R9).
      for (int v = 0; v < NVEC; v++) begin
         hdr_i = VEC[v][HW+WW-1 -: HW];
         data_i = VEC[v][WW-1:0];
         start_i = 1'b1;
         capture(VEC[v][HW+WW-1 -: HW], VEC[v][WW-1:0], 1'b0);
      end
      @(negedge clk);
      chk(!done_o, "R7 done lasts one clock", 64'(done_o), 64'd0);
      begin
         bit quiet;
         quiet = 1'b1;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (tx_o || busy_o) quiet = 1'b0;
         end
         chk(quiet, "R9 idle line low", 64'(quiet), 64'd1);
      end

      // Request and new inputs while busy must not disturb the frame (R8).
      hdr_i = 5'h0C;
      data_i = 32'h0F1E_2D3C;
      start_i = 1'b1;
      capture(5'h0C, 32'h0F1E_2D3C, 1'b1);
      @(negedge clk);

      // Asynchronous reset in the middle of a frame (R1).
      hdr_i = 5'h07;
      data_i = 32'h7777_0000;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (100) @(negedge clk);
      chk(busy_o, "R2 busy mid-frame", 64'(busy_o), 64'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!tx_o && !busy_o && !done_o, "R1 outputs after async reset",
          {61'd0, tx_o, busy_o, done_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      hdr_i = 5'h1A;
      data_i = 32'hC001_D00D;
      start_i = 1'b1;
      capture(5'h1A, 32'hC001_D00D, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule